// File: doc/BRIEF.md
# Banked Dual Stack Pointer Unit

This block keeps two word-aligned stack pointers, a main pointer and a process pointer. Only one of them is visible at a time, as the active stack pointer. The choice depends on the processor mode and a selection bit. In handler mode the main pointer is always active. In thread mode the selection bit picks the pointer. A control write sets the selection bit, and so does an exception-return selector on the way out of an exception. After reset all execution runs on the main stack.

The stack is full descending, so the active pointer always holds the address of the last item stacked. A push lowers the active pointer by one word and writes the item at the new address. A pop reads the word at the current address and then raises the pointer by one word. The block drives a simple word-wide memory port and takes the read data back in the same cycle. Software may also write either pointer directly. The main pointer takes its reset value from an input word that stands in for the first vector-table entry.

Top module: `dual_sp_bank`

## Requirements
- R1: During reset (`rstN` low at a clock edge) the main pointer loads `resetVector` with bits [1:0] cleared, the process pointer loads 0, and the selection bit clears. After reset the main pointer is active (`activeIsProc`=0), and `stackErr` and `popValid` are 0.
- R2: In thread mode (`handlerMode`=0), `activeSp` shows the process pointer when the selection bit is 1 and the main pointer when it is 0. `activeIsProc` shows which one is shown.
- R3: In handler mode (`handlerMode`=1), `activeSp` shows the main pointer whatever the selection bit is, and pushes and pops act on the main pointer.
- R4: A control write (`ctrlWrEn`=1) loads `ctrlWrSel` into the selection bit. The change takes effect from the next cycle.
- R5: An exception return (`excRetEn`=1) loads `excRetProc` into the selection bit from the next cycle (1 selects the process stack). If a control write comes in the same cycle, the exception return wins.
- R6: A push (`pushReq`=1) drives, in the same cycle, `memWrEn`=1, `memAddr` = `activeSp` − 4 and `memWrData` = `pushData`. From the next cycle the active pointer is 4 lower.
- R7: A pop (`popReq`=1 with `pushReq`=0) drives, in the same cycle, `memRdEn`=1 and `memAddr` = `activeSp`. In the next cycle `popValid`=1, `popData` holds the `memRdData` of the pop cycle, and the active pointer is 4 higher.
- R8: Direct writes (`mainWrEn`, `procWrEn`) load the pointer with bits [1:0] forced to 0. A direct write to a pointer wins over a push or pop that would move that same pointer in that cycle.
- R9: When push and pop are requested in the same cycle, only the push is carried out: `memRdEn`=0, and `popValid` stays 0 next cycle. `stackErr` is 1 in the next cycle only.
- R10: A push or pop leaves the inactive pointer unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous reset, active low |
| resetVector | input | 32 | Reset value of the main pointer |
| handlerMode | input | 1 | 1 = handler mode, 0 = thread mode |
| ctrlWrEn | input | 1 | Control write strobe for the selection bit |
| ctrlWrSel | input | 1 | Value of the selection bit for a control write |
| excRetEn | input | 1 | Exception-return strobe |
| excRetProc | input | 1 | Exception return to the process stack when 1 |
| pushReq | input | 1 | Push request |
| pushData | input | 32 | Word to push |
| popReq | input | 1 | Pop request |
| mainWrEn | input | 1 | Direct write to the main pointer |
| mainWrData | input | 32 | Data for a direct write to the main pointer |
| procWrEn | input | 1 | Direct write to the process pointer |
| procWrData | input | 32 | Data for a direct write to the process pointer |
| memRdData | input | 32 | Read data from memory, valid in the same cycle |
| activeSp | output | 32 | Active stack pointer |
| activeIsProc | output | 1 | 1 when the process pointer is active |
| memAddr | output | 32 | Memory word address |
| memWrEn | output | 1 | Memory write strobe |
| memWrData | output | 32 | Memory write data |
| memRdEn | output | 1 | Memory read strobe |
| popData | output | 32 | Last popped word |
| popValid | output | 1 | Pulses for one cycle after a pop |
| stackErr | output | 1 | Pulses for one cycle after a push and a pop in the same cycle |

## Verification
The assertions take the memory to return read data in the same cycle as the address, with no wait states. The check that a push lowers the pointer holds only when no direct pointer write, control write, exception return or mode change lands in the push cycle, and only if the mode does not change in the following cycle. The directed stimulus drives every input just after the falling edge. It keeps all addresses inside a small memory model that decodes address bits [9:2]. It combines a push with a pointer write, or a push with a pop, only in the tests that check those collisions.

// File: rtl/dsp_pkg.sv
package dsp_pkg;
  typedef struct packed {
    logic doPush;
    logic doPop;
    logic useProc;
    logic errSet;
  } spCtl_t;
endpackage

// File: rtl/dsp_ctrl.sv
module dsp_ctrl
  import dsp_pkg::*;
(
  input  logic   clk,
  input  logic   rstN,
  input  logic   handlerMode,
  input  logic   ctrlWrEn,
  input  logic   ctrlWrSel,
  input  logic   excRetEn,
  input  logic   excRetProc,
  input  logic   pushReq,
  input  logic   popReq,
  output spCtl_t ctl,
  output logic   stackErr
);
  logic selBit;

  // exception return has priority over a plain control write
  always_ff @(posedge clk) begin
    if (!rstN) begin
      selBit <= 1'b0;
    end else if (excRetEn) begin
      selBit <= excRetProc;
    end else if (ctrlWrEn) begin
      selBit <= ctrlWrSel;
    end
  end

  always_comb begin
    ctl.doPush  = pushReq;
    ctl.doPop   = popReq & ~pushReq;
    ctl.useProc = selBit & ~handlerMode;
    ctl.errSet  = pushReq & popReq;
  end

  always_ff @(posedge clk) begin
    if (!rstN) stackErr <= 1'b0;
    else       stackErr <= ctl.errSet;
  end
endmodule

// File: rtl/dsp_datapath.sv
module dsp_datapath
  import dsp_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  spCtl_t            ctl,
  input  logic [DATA_W-1:0] resetVector,
  input  logic [DATA_W-1:0] pushData,
  input  logic              mainWrEn,
  input  logic [DATA_W-1:0] mainWrData,
  input  logic              procWrEn,
  input  logic [DATA_W-1:0] procWrData,
  input  logic [DATA_W-1:0] memRdData,
  output logic [DATA_W-1:0] activeSp,
  output logic [DATA_W-1:0] memAddr,
  output logic              memWrEn,
  output logic [DATA_W-1:0] memWrData,
  output logic              memRdEn,
  output logic [DATA_W-1:0] popData,
  output logic              popValid
);
  localparam int STEP      = DATA_W / 8;
  localparam int ALIGN     = $clog2(STEP);
  localparam int NUM_BANKS = 2;
  localparam logic [DATA_W-1:0] STEP_V = DATA_W'(STEP);

  logic [DATA_W-1:0] bankPtr [NUM_BANKS];
  logic [DATA_W-1:0] bankWrData [NUM_BANKS];
  logic [DATA_W-1:0] bankRst [NUM_BANKS];
  logic              bankWrEn [NUM_BANKS];

  function automatic logic [DATA_W-1:0] alignWord(input logic [DATA_W-1:0] v);
    return {v[DATA_W-1:ALIGN], {ALIGN{1'b0}}};
  endfunction

  always_comb begin
    bankWrEn[0]   = mainWrEn;
    bankWrEn[1]   = procWrEn;
    bankWrData[0] = mainWrData;
    bankWrData[1] = procWrData;
    bankRst[0]    = resetVector;
    bankRst[1]    = '0;
  end

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    logic isActive;
    assign isActive = (ctl.useProc == (b == 1));
    always_ff @(posedge clk) begin
      if (!rstN) begin
        bankPtr[b] <= alignWord(bankRst[b]);
      end else if (bankWrEn[b]) begin
        bankPtr[b] <= alignWord(bankWrData[b]);
      end else if (isActive && ctl.doPush) begin
        bankPtr[b] <= bankPtr[b] - STEP_V;
      end else if (isActive && ctl.doPop) begin
        bankPtr[b] <= bankPtr[b] + STEP_V;
      end
    end
  end

  always_comb begin
    activeSp  = ctl.useProc ? bankPtr[1] : bankPtr[0];
    memAddr   = ctl.doPush ? (activeSp - STEP_V) : activeSp;
    memWrEn   = ctl.doPush;
    memWrData = pushData;
    memRdEn   = ctl.doPop;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      popData  <= '0;
      popValid <= 1'b0;
    end else begin
      popValid <= ctl.doPop;
      if (ctl.doPop) popData <= memRdData;
    end
  end
endmodule

// File: rtl/dual_sp_bank.sv
module dual_sp_bank
  import dsp_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [DATA_W-1:0] resetVector,
  input  logic              handlerMode,
  input  logic              ctrlWrEn,
  input  logic              ctrlWrSel,
  input  logic              excRetEn,
  input  logic              excRetProc,
  input  logic              pushReq,
  input  logic [DATA_W-1:0] pushData,
  input  logic              popReq,
  input  logic              mainWrEn,
  input  logic [DATA_W-1:0] mainWrData,
  input  logic              procWrEn,
  input  logic [DATA_W-1:0] procWrData,
  input  logic [DATA_W-1:0] memRdData,
  output logic [DATA_W-1:0] activeSp,
  output logic              activeIsProc,
  output logic [DATA_W-1:0] memAddr,
  output logic              memWrEn,
  output logic [DATA_W-1:0] memWrData,
  output logic              memRdEn,
  output logic [DATA_W-1:0] popData,
  output logic              popValid,
  output logic              stackErr
);
  spCtl_t ctl;

  dsp_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .handlerMode(handlerMode),
    .ctrlWrEn(ctrlWrEn), .ctrlWrSel(ctrlWrSel),
    .excRetEn(excRetEn), .excRetProc(excRetProc),
    .pushReq(pushReq), .popReq(popReq),
    .ctl(ctl), .stackErr(stackErr)
  );

  dsp_datapath #(.DATA_W(DATA_W)) u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl),
    .resetVector(resetVector), .pushData(pushData),
    .mainWrEn(mainWrEn), .mainWrData(mainWrData),
    .procWrEn(procWrEn), .procWrData(procWrData),
    .memRdData(memRdData), .activeSp(activeSp),
    .memAddr(memAddr), .memWrEn(memWrEn), .memWrData(memWrData),
    .memRdEn(memRdEn), .popData(popData), .popValid(popValid)
  );

  assign activeIsProc = ctl.useProc;
endmodule

// File: rtl/dual_sp_bank_checker.sv
module dual_sp_bank_checker #(
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic              handlerMode,
  input logic              ctrlWrEn,
  input logic              excRetEn,
  input logic              pushReq,
  input logic              popReq,
  input logic              mainWrEn,
  input logic              procWrEn,
  input logic [DATA_W-1:0] pushData,
  input logic [DATA_W-1:0] memRdData,
  input logic [DATA_W-1:0] activeSp,
  input logic              activeIsProc,
  input logic [DATA_W-1:0] memAddr,
  input logic              memWrEn,
  input logic [DATA_W-1:0] memWrData,
  input logic              memRdEn,
  input logic [DATA_W-1:0] popData,
  input logic              popValid,
  input logic              stackErr
);
  localparam logic [DATA_W-1:0] STEP_V = DATA_W'(DATA_W / 8);

  AST_MAIN_AFTER_RESET: assert property (@(posedge clk) disable iff (!rstN)
    !$past(rstN) |-> (!activeIsProc && !stackErr && !popValid)); // R1

  AST_PUSH_PORT: assert property (@(posedge clk) disable iff (!rstN)
    pushReq |-> (memWrEn && memAddr == activeSp - STEP_V && memWrData == pushData)); // R6

  AST_PUSH_DEC: assert property (@(posedge clk) disable iff (!rstN)
    (pushReq && !mainWrEn && !procWrEn && !ctrlWrEn && !excRetEn)
    |=> (handlerMode != $past(handlerMode)) || (activeSp == $past(activeSp) - STEP_V)); // R6

  AST_POP_DATA: assert property (@(posedge clk) disable iff (!rstN)
    (popReq && !pushReq) |=> (popValid && popData == $past(memRdData))); // R7

  AST_WORD_ALIGN: assert property (@(posedge clk) disable iff (!rstN)
    activeSp[1:0] == 2'b00); // R8

  AST_COLLIDE_ERR: assert property (@(posedge clk) disable iff (!rstN)
    (pushReq && popReq) |=> (stackErr && !popValid)); // R9

  AST_NO_READ_ON_COLLIDE: assert property (@(posedge clk) disable iff (!rstN)
    (pushReq && popReq) |-> (!memRdEn && memWrEn)); // R9

  AST_HANDLER_MAIN: assert property (@(posedge clk) disable iff (!rstN)
    (handlerMode && !$past(handlerMode) && !$past(mainWrEn) && !$past(pushReq) && !$past(popReq)
     && !$past(activeIsProc)) |-> $stable(activeSp)); // R3
endmodule

bind dual_sp_bank dual_sp_bank_checker #(.DATA_W(DATA_W)) u_checker (
  .clk(clk), .rstN(rstN), .handlerMode(handlerMode),
  .ctrlWrEn(ctrlWrEn), .excRetEn(excRetEn),
  .pushReq(pushReq), .popReq(popReq),
  .mainWrEn(mainWrEn), .procWrEn(procWrEn),
  .pushData(pushData), .memRdData(memRdData),
  .activeSp(activeSp), .activeIsProc(activeIsProc),
  .memAddr(memAddr), .memWrEn(memWrEn), .memWrData(memWrData),
  .memRdEn(memRdEn), .popData(popData), .popValid(popValid),
  .stackErr(stackErr)
);

// File: tb/dual_sp_bank_bench.sv
module dual_sp_bank_bench;
  logic        clk = 1'b0;
  logic        rstN;
  logic [31:0] resetVector;
  logic        handlerMode, ctrlWrEn, ctrlWrSel, excRetEn, excRetProc;
  logic        pushReq, popReq, mainWrEn, procWrEn;
  logic [31:0] pushData, mainWrData, procWrData, memRdData;
  logic [31:0] activeSp, memAddr, memWrData, popData;
  logic        activeIsProc, memWrEn, memRdEn, popValid, stackErr;

  int checks = 0;
  int fails  = 0;
  logic [31:0] mem [256];

  always #10 clk = ~clk;

  dual_sp_bank u_dual_sp_bank (
    .clk(clk), .rstN(rstN), .resetVector(resetVector),
    .handlerMode(handlerMode), .ctrlWrEn(ctrlWrEn), .ctrlWrSel(ctrlWrSel),
    .excRetEn(excRetEn), .excRetProc(excRetProc),
    .pushReq(pushReq), .pushData(pushData), .popReq(popReq),
    .mainWrEn(mainWrEn), .mainWrData(mainWrData),
    .procWrEn(procWrEn), .procWrData(procWrData),
    .memRdData(memRdData), .activeSp(activeSp), .activeIsProc(activeIsProc),
    .memAddr(memAddr), .memWrEn(memWrEn), .memWrData(memWrData),
    .memRdEn(memRdEn), .popData(popData), .popValid(popValid),
    .stackErr(stackErr)
  );

  assign memRdData = mem[memAddr[9:2]];
  always @(posedge clk) if (memWrEn) mem[memAddr[9:2]] <= memWrData;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic idle();
    ctrlWrEn = 0; excRetEn = 0; pushReq = 0; popReq = 0;
    mainWrEn = 0; procWrEn = 0;
  endtask

  // drive after negedge, combinational sample 2 ns later
  task automatic nextCycle();
    @(negedge clk);
    idle();
  endtask

  task automatic t_reset();
    rstN = 0; idle(); handlerMode = 0; ctrlWrSel = 0; excRetProc = 0;
    pushData = 0; mainWrData = 0; procWrData = 0;
    resetVector = 32'h0000_0403;
    repeat (3) @(negedge clk);
    rstN = 1;
    #2;
    check("R1 main reset aligned", activeSp, 32'h400);
    check("R1 main active", {31'b0, activeIsProc}, 0);
    check("R1 stackErr", {31'b0, stackErr}, 0);
    check("R1 popValid", {31'b0, popValid}, 0);
  endtask

  task automatic t_select();
    @(negedge clk); idle(); ctrlWrEn = 1; ctrlWrSel = 1;
    #2 check("R4 not yet switched", activeSp, 32'h400);
    nextCycle(); #2;
    check("R4 R2 process active", {31'b0, activeIsProc}, 1);
    check("R1 process reset zero", activeSp, 32'h0);
    @(negedge clk); idle(); procWrEn = 1; procWrData = 32'h203;
    nextCycle(); #2;
    check("R8 process write aligned", activeSp, 32'h200);
  endtask

  task automatic t_handler();
    @(negedge clk); idle(); handlerMode = 1;
    #2 check("R3 handler shows main", activeSp, 32'h400);
    check("R3 handler flag", {31'b0, activeIsProc}, 0);
    handlerMode = 0;
    #2 check("R2 thread shows process", activeSp, 32'h200);
  endtask

  task automatic t_push();
    @(negedge clk); idle(); pushReq = 1; pushData = 32'hAAAA_0001;
    #2 check("R6 push addr", memAddr, 32'h1FC);
    check("R6 push strobe", {31'b0, memWrEn}, 1);
    check("R6 push data", memWrData, 32'hAAAA_0001);
    nextCycle(); #2;
    check("R6 pointer down", activeSp, 32'h1FC);
    @(negedge clk); idle(); pushReq = 1; pushData = 32'hBBBB_0002;
    nextCycle(); #2;
    check("R6 second push", activeSp, 32'h1F8);
    handlerMode = 1; #2;
    check("R10 main untouched", activeSp, 32'h400);
    handlerMode = 0;
  endtask

  task automatic t_pop();
    @(negedge clk); idle(); popReq = 1;
    #2 check("R7 pop addr", memAddr, 32'h1F8);
    check("R7 read strobe", {31'b0, memRdEn}, 1);
    nextCycle(); #2;
    check("R7 pop data", popData, 32'hBBBB_0002);
    check("R7 pop valid", {31'b0, popValid}, 1);
    check("R7 pointer up", activeSp, 32'h1FC);
  endtask

  task automatic t_collide();
    @(negedge clk); idle(); pushReq = 1; popReq = 1; pushData = 32'hCCCC_0003;
    #2 check("R9 no read", {31'b0, memRdEn}, 0);
    check("R9 write kept", {31'b0, memWrEn}, 1);
    nextCycle(); #2;
    check("R9 error flag", {31'b0, stackErr}, 1);
    check("R9 no pop valid", {31'b0, popValid}, 0);
    check("R9 push done", activeSp, 32'h1F8);
    nextCycle(); #2;
    check("R9 error one cycle", {31'b0, stackErr}, 0);
  endtask

  task automatic t_excret();
    @(negedge clk); idle(); excRetEn = 1; excRetProc = 0; ctrlWrEn = 1; ctrlWrSel = 1;
    nextCycle(); #2;
    check("R5 exc return wins", activeSp, 32'h400);
    @(negedge clk); idle(); excRetEn = 1; excRetProc = 1;
    nextCycle(); #2;
    check("R5 return to process", activeSp, 32'h1F8);
  endtask

  task automatic t_override();
    @(negedge clk); idle(); pushReq = 1; pushData = 32'h1; procWrEn = 1; procWrData = 32'h305;
    nextCycle(); #2;
    check("R8 write beats push", activeSp, 32'h304);
    handlerMode = 1;
    @(negedge clk); idle(); pushReq = 1; pushData = 32'h2;
    nextCycle(); #2;
    check("R3 handler push on main", activeSp, 32'h3FC);
    handlerMode = 0; #2;
    check("R10 process untouched", activeSp, 32'h304);
    @(negedge clk); idle(); mainWrEn = 1; mainWrData = 32'h7FF;
    nextCycle(); handlerMode = 1; #2;
    check("R8 main write aligned", activeSp, 32'h7FC);
    handlerMode = 0;
  endtask

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 32'h0;
    t_reset();
    t_select();
    t_handler();
    t_push();
    t_pop();
    t_collide();
    t_excret();
    t_override();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #1000000;
    checks++; fails++;
    $display("FAIL watchdog expired actual=%h expected=%h", 0, 1);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule